// File: doc/BRIEF.md
# Asynchronous Strobed Host Port Master

This block lets synchronous logic run single read and write accesses on an asynchronous parallel host port. That port has an active-low chip select, an active-low data strobe, a read/write line (high for read), an address bus and a data bus that is split here into output, output enable and input. A caller places a request on a valid/ready command interface. The block presents the address and direction. It pulls both strobes low for a timed pulse and raises them again. It holds the bus through a short hold phase and then keeps the port quiet for a recovery interval before it takes the next request. Each access ends with a one-cycle response pulse, and a read also returns the sampled data.

The peripheral's minimum pulse width and recovery both scale with its internal DSP clock period. That period is slow until the peripheral has booted and fast afterwards. All intervals are converted into whole system-clock counts at elaboration, rounded up. A `bootDone` input picks the slow or fast count set, and it is sampled once per access, when the command is accepted.

Top module: `host_strobe_master`

## Requirements
- R1: After reset both strobes are high, `busRw` is high (read), `busDataOe` is low, `rspValid` is low and `cmdReady` is high.
- R2: Address and direction are set when a command is accepted. They stay unchanged for at least ceil(5 ns / Tclk) cycles before both strobes fall together, and they stay unchanged while the strobes are low. `busRw` high means read and low means write.
- R3: The strobes stay low for max(ceil((Tdsp + 10 ns) / Tclk), ceil(21 ns / Tclk) + 1) cycles. With the defaults (4 ns clock, Tdsp of 100 ns before boot and 15.4 ns after) this is 28 cycles (112 ns) and 7 cycles (28 ns).
- R4: From the strobe rise that ends one access to the fall that starts the next, the strobes stay high for at least 2*Tdsp + 10 ns, using the Tdsp of the access that just ended. `cmdReady` is low from the accept edge until that interval has elapsed, and a command is not taken while `cmdReady` is low.
- R5: `busDataOe` is high only during a write, never while `busRw` is high. Write data is valid from the setup phase onward, stays stable while the strobes are low, and is held with the address and direction for at least 5 ns after the strobe rise.
- R6: Read data is sampled at the clock edge one cycle before the strobes rise. It is returned on `rspRdata` together with `rspValid`.
- R7: Every access, read or write, produces exactly one `rspValid` pulse lasting one cycle, after its hold phase.
- R8: `bootDone` is sampled on the edge that accepts a command. A change of `bootDone` during an access does not alter that access's pulse width or recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bootDone | input | 1 | 1 selects the post-boot (fast) timing profile |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command can be accepted |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Access address |
| cmdWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Sampled read data |
| busCsN | output | 1 | Chip select, active low |
| busDsN | output | 1 | Data strobe, active low |
| busRw | output | 1 | Direction, high = read |
| busAddr | output | ADDR_W | Port address |
| busDataOut | output | DATA_W | Data driven on writes |
| busDataOe | output | 1 | Data output enable |
| busDataIn | input | DATA_W | Data from the peripheral |

## Verification
Two things can land on the same clock edge. One is the end of the recovery count, which is exactly when a waiting command gets accepted. The other is a change of `bootDone`, which has to be captured for the new access and must not touch the access already running. The bench keeps `cmdValid` asserted through whole recovery intervals and changes `bootDone` in the same cycle a command is offered. It also flips `bootDone` back in the middle of a strobe pulse. A timing model of the peripheral measures the pulse width and the strobe-high gap in nanoseconds for each of these accesses. Both are compared with the profile that was captured at acceptance.

// File: rtl/hsm_pkg.sv
`timescale 1ns/1ps
package hsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } hsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic strobeLow;
    logic driveData;
    logic captureRd;
    logic rspPulse;
  } hsmCtl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/hsm_ctrl.sv
`timescale 1ns/1ps
module hsm_ctrl
  import hsm_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int PULSE_SLOW = 28,
  parameter int PULSE_FAST = 7,
  parameter int REC_SLOW   = 53,
  parameter int REC_FAST   = 11,
  parameter int CNT_W      = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdWrite,
  input  logic    bootDone,
  output logic    cmdReady,
  output hsmCtl_t ctl
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] PSLOW_LD = CNT_W'(PULSE_SLOW - 1);
  localparam logic [CNT_W-1:0] PFAST_LD = CNT_W'(PULSE_FAST - 1);
  localparam logic [CNT_W-1:0] RSLOW_LD = CNT_W'(REC_SLOW);
  localparam logic [CNT_W-1:0] RFAST_LD = CNT_W'(REC_FAST);

  hsmState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] recCnt;
  logic             fastSel;
  logic             isWrite;
  logic             accept;
  logic             phaseDone;

  assign cmdReady  = (state == ST_IDLE) && (recCnt == '0);
  assign accept    = cmdReady && cmdValid;
  assign phaseDone = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      recCnt   <= '0;
      fastSel  <= 1'b0;
      isWrite  <= 1'b0;
    end else begin
      if (recCnt != '0) recCnt <= recCnt - 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_SETUP;
          phaseCnt <= SETUP_LD;
          fastSel  <= bootDone;
          isWrite  <= cmdWrite;
        end
        ST_SETUP: if (phaseDone) begin
          state    <= ST_STROBE;
          phaseCnt <= fastSel ? PFAST_LD : PSLOW_LD;
        end else begin
          phaseCnt <= phaseCnt - 1'b1;
        end
        ST_STROBE: if (phaseDone) begin
          state    <= ST_HOLD;
          phaseCnt <= HOLD_LD;
          recCnt   <= fastSel ? RFAST_LD : RSLOW_LD;
        end else begin
          phaseCnt <= phaseCnt - 1'b1;
        end
        default: if (phaseDone) begin
          state <= ST_IDLE;
        end else begin
          phaseCnt <= phaseCnt - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl.loadCmd   = accept;
    ctl.strobeLow = (state == ST_STROBE);
    ctl.driveData = isWrite && (state != ST_IDLE);
    ctl.captureRd = (state == ST_STROBE) && !isWrite && (phaseCnt == CNT_W'(1));
    ctl.rspPulse  = (state == ST_HOLD) && phaseDone;
  end

endmodule

// File: rtl/hsm_datapath.sv
`timescale 1ns/1ps
module hsm_datapath
  import hsm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsmCtl_t           ctl,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busCsN,
  output logic              busDsN,
  output logic              busRw,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rwQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rwQ    <= 1'b1;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= ctl.rspPulse;
      if (ctl.loadCmd) begin
        addrQ  <= cmdAddr;
        wdataQ <= cmdWdata;
        rwQ    <= !cmdWrite;
      end
      if (ctl.captureRd) rdataQ <= busDataIn;
    end
  end

  assign busCsN     = !ctl.strobeLow;
  assign busDsN     = !ctl.strobeLow;
  assign busRw      = rwQ;
  assign busAddr    = addrQ;
  assign busDataOut = wdataQ;
  assign busDataOe  = ctl.driveData;
  assign rspValid   = rspQ;
  assign rspRdata   = rdataQ;

endmodule

// File: rtl/host_strobe_master.sv
`timescale 1ns/1ps
module host_strobe_master
  import hsm_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 16,
  parameter int CLK_PS        = 4000,
  parameter int SLOW_DCLK_PS  = 100000,
  parameter int FAST_DCLK_PS  = 15400,
  parameter int MARGIN_PS     = 10000,
  parameter int ADDR_SETUP_PS = 5000,
  parameter int HOLD_PS       = 5000,
  parameter int RD_VALID_PS   = 21000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootDone,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              busCsN,
  output logic              busDsN,
  output logic              busRw,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn
);

  localparam int SETUP_CYC  = atLeast(ceilDiv(ADDR_SETUP_PS, CLK_PS), 1);
  localparam int HOLD_CYC   = atLeast(ceilDiv(HOLD_PS, CLK_PS), 1);
  localparam int RD_MIN     = atLeast(ceilDiv(RD_VALID_PS, CLK_PS) + 1, 2);
  localparam int PULSE_SLOW = atLeast(ceilDiv(SLOW_DCLK_PS + MARGIN_PS, CLK_PS), RD_MIN);
  localparam int PULSE_FAST = atLeast(ceilDiv(FAST_DCLK_PS + MARGIN_PS, CLK_PS), RD_MIN);
  localparam int REC_SLOW   = atLeast(ceilDiv(2 * SLOW_DCLK_PS + MARGIN_PS, CLK_PS), HOLD_CYC);
  localparam int REC_FAST   = atLeast(ceilDiv(2 * FAST_DCLK_PS + MARGIN_PS, CLK_PS), HOLD_CYC);
  localparam int CNT_MAX    = atLeast(atLeast(REC_SLOW, REC_FAST), atLeast(PULSE_SLOW, PULSE_FAST));
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  hsmCtl_t ctl;

  hsm_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .PULSE_SLOW(PULSE_SLOW),
    .PULSE_FAST(PULSE_FAST),
    .REC_SLOW  (REC_SLOW),
    .REC_FAST  (REC_FAST),
    .CNT_W     (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdWrite(cmdWrite),
    .bootDone(bootDone),
    .cmdReady(cmdReady),
    .ctl     (ctl)
  );

  hsm_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmdWrite  (cmdWrite),
    .cmdAddr   (cmdAddr),
    .cmdWdata  (cmdWdata),
    .busDataIn (busDataIn),
    .busCsN    (busCsN),
    .busDsN    (busDsN),
    .busRw     (busRw),
    .busAddr   (busAddr),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .rspValid  (rspValid),
    .rspRdata  (rspRdata)
  );

endmodule

// File: rtl/hsm_checker.sv
`timescale 1ns/1ps
module hsm_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PULSE_MIN = 7,
  parameter int GAP_MIN   = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              rspValid,
  input logic              busCsN,
  input logic              busDsN,
  input logic              busRw,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe
);

  int lowRun;
  int highRun;
  logic seenLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= 0;
      highRun <= 0;
      seenLow <= 1'b0;
    end else begin
      lowRun  <= busCsN ? 0 : lowRun + 1;
      if (!busCsN) begin
        highRun <= 0;
        seenLow <= 1'b1;
      end else if (highRun < 1000000) begin
        highRun <= highRun + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && busCsN && lowRun != 0)
      AST_PULSE_MIN: assert (lowRun >= PULSE_MIN) else $error("strobe pulse %0d", lowRun); // R3
    if (rstN && !busCsN && seenLow && highRun != 0)
      AST_GAP_MIN: assert (highRun >= GAP_MIN) else $error("strobe gap %0d", highRun); // R4
  end

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rstN) (busCsN == busDsN)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> ($stable(busAddr) && $stable(busRw))); // R2
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rstN) busDataOe |-> !busRw); // R5
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut)); // R5
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (busCsN && !busDataOe)); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid); // R7

endmodule

bind host_strobe_master hsm_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PULSE_MIN(PULSE_FAST),
  .GAP_MIN  (REC_FAST)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdReady  (cmdReady),
  .rspValid  (rspValid),
  .busCsN    (busCsN),
  .busDsN    (busDsN),
  .busRw     (busRw),
  .busAddr   (busAddr),
  .busDataOut(busDataOut),
  .busDataOe (busDataOe)
);

// File: tb/sim_host_strobe_master.sv
`timescale 1ns/1ps
module sim_host_strobe_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootDone = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [7:0]  cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic        cmdReady, rspValid, busCsN, busDsN, busRw, busDataOe;
  logic [15:0] rspRdata, busDataOut, busDataIn;
  logic [7:0]  busAddr;

  always #2 clk = !clk;

  host_strobe_master u0 (
    .clk(clk), .rstN(rstN), .bootDone(bootDone), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .busCsN(busCsN), .busDsN(busDsN), .busRw(busRw), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkMin(input string req, input real act, input real lo);
    compared++;
    if (act < lo) begin
      mismatched++;
      $display("FAIL %s actual=%0.2f expected>=%0.2f", req, act, lo);
    end
  endtask

  // peripheral model
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic rdValid = 1'b0;
  wire active = !busCsN && !busDsN;
  realtime tAddr = -1000, tRw = -1000, tData = -1000, tStart = 0, tEnd = 0;
  real curDclk = 100.0, prevDclk = 100.0, lastPulse = 0.0;
  bit started = 0, ended = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = {i[7:0], ~i[7:0]};
      shadow[i] = {i[7:0], ~i[7:0]};
    end
  end

  assign busDataIn = rdValid ? mem[busAddr] : 16'hDEAD;

  always @(busAddr) tAddr = $realtime;
  always @(busRw) tRw = $realtime;
  always @(busDataOut or busDataOe) tData = $realtime;

  always @(posedge active) begin
    rdValid = 1'b0;
    #20 rdValid = active && busRw;
  end
  always @(negedge active) begin
    #5 rdValid = 1'b0;
  end

  always @(active) begin
    if (active) begin
      tStart = $realtime;
      started = 1;
      chkMin("R2 address setup", tStart - tAddr, 5.0);
      chkMin("R2 direction setup", tStart - tRw, 5.0);
      if (ended) chkMin("R4 recovery gap", tStart - tEnd, 2.0 * prevDclk + 10.0);
    end else if (started) begin
      automatic bit wasWrite = !busRw;
      tEnd = $realtime;
      lastPulse = tEnd - tStart;
      chkMin("R3 pulse width", lastPulse, curDclk + 10.0);
      chk("R2 address held while low", 32'(tAddr < tStart), 32'd1);
      if (wasWrite) begin
        chk("R5 output enable on write", 32'(busDataOe), 32'd1);
        chkMin("R5 write data setup", tEnd - tData, 20.0);
        mem[busAddr] = busDataOut;
      end
      prevDclk = curDclk;
      ended = 1;
      #5;
      chk("R5 direction hold", 32'(tRw <= tEnd), 32'd1);
      chk("R5 address hold", 32'(tAddr <= tEnd), 32'd1);
      if (wasWrite) chk("R5 write data hold", 32'(tData <= tEnd), 32'd1);
    end
  end

  task automatic doXfer(input logic boot, input logic wr, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bootDone = boot; cmdValid = 1'b1; cmdWrite = wr; cmdAddr = a; cmdWdata = d;
    curDclk = boot ? 15.4 : 100.0;
    while (!cmdReady) @(negedge clk);
    if (wr) shadow[a] = d;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!rspValid) @(negedge clk);
  endtask

  // {boot, write, addr, data}
  localparam logic [25:0] VEC [10] = '{
    {1'b0, 1'b1, 8'h10, 16'h1234},
    {1'b0, 1'b0, 8'h10, 16'h0000},
    {1'b0, 1'b0, 8'h22, 16'h0000},
    {1'b1, 1'b1, 8'h22, 16'hBEEF},
    {1'b1, 1'b0, 8'h22, 16'h0000},
    {1'b1, 1'b1, 8'hFF, 16'hA5C3},
    {1'b1, 1'b0, 8'hFF, 16'h0000},
    {1'b0, 1'b0, 8'h00, 16'h0000},
    {1'b1, 1'b1, 8'h01, 16'h0F0F},
    {1'b1, 1'b0, 8'h01, 16'h0000}
  };

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 chip select idle", 32'(busCsN), 32'd1);
    chk("R1 data strobe idle", 32'(busDsN), 32'd1);
    chk("R1 direction read", 32'(busRw), 32'd1);
    chk("R1 output enable off", 32'(busDataOe), 32'd0);
    chk("R1 response low", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(cmdReady), 32'd1);

    foreach (VEC[i]) begin
      automatic logic       vb = VEC[i][25];
      automatic logic       vw = VEC[i][24];
      automatic logic [7:0] va = VEC[i][23:16];
      doXfer(vb, vw, va, VEC[i][15:0]);
      chk("R3 pulse cycles", 32'($rtoi(lastPulse)), vb ? 32'd28 : 32'd112);
      if (!vw) chk("R6 read data", 32'(rspRdata), 32'(shadow[va]));
      chk("R4 not ready at response", 32'(cmdReady), 32'd0);
      @(negedge clk);
      chk("R7 response one cycle", 32'(rspValid), 32'd0);
    end

    // R4: ready only after the full recovery from the strobe rise
    doXfer(1'b0, 1'b1, 8'h40, 16'h7777);
    while (!cmdReady) @(negedge clk);
    chkMin("R4 ready after slow recovery", $realtime - tEnd, 210.0);

    // R8: bootDone captured on the accept edge, later change ignored
    @(negedge clk);
    bootDone = 1'b1; cmdValid = 1'b1; cmdWrite = 1'b0; cmdAddr = 8'h40;
    curDclk = 15.4;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    bootDone = 1'b0;
    while (!rspValid) @(negedge clk);
    chk("R8 profile kept during access", 32'($rtoi(lastPulse)), 32'd28);
    chk("R6 read after mode switch", 32'(rspRdata), 32'h7777);
    doXfer(1'b0, 1'b0, 8'h40, 16'h0000);
    chk("R8 new profile on next access", 32'($rtoi(lastPulse)), 32'd112);

    // R4: back-to-back commands held valid, accepted only when ready
    @(negedge clk);
    bootDone = 1'b1; cmdValid = 1'b1; cmdWrite = 1'b1; cmdAddr = 8'h55; cmdWdata = 16'h1357;
    curDclk = 15.4;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    chk("R4 ready drops on accept", 32'(cmdReady), 32'd0);
    cmdAddr = 8'h56; cmdWdata = 16'h2468;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    chk("R5 write reached peripheral", 32'(mem[8'h56]), 32'h2468);
    chk("R4 first write landed", 32'(mem[8'h55]), 32'h1357);

    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule